// File: doc/BRIEF.md
# Device Address Translation Walker with Fault Capture

This block turns a device virtual address into a physical address by reading a single 32-bit page-table entry from memory. The entry's memory address is formed from a page-table base value and a window-start mask, both supplied as plain configuration inputs. The block checks the entry's present bit. For writes it also checks the entry's write-permission bit. On success it returns the physical page from the entry joined with the 4 KB page offset. On failure it returns a fault and updates two fault-capture registers: a fixed-format status word and the page-aligned faulting address.

The request, memory-read and response interfaces use valid/ready handshakes. A request is taken only while `req_ready` is high, and `req_ready` is high only when the walker is idle. The memory read request is held, with its address stable, until `pte_req_ready` is sampled high. After that the block waits for a single `pte_rsp_valid` beat. The response is held, with its contents stable, until `rsp_ready` is sampled high. Only then can the next request be taken. No memory is cached between requests.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `pte_req_valid` are 0, and both `flt_status` and `flt_addr` are 0.
- R2: The entry address on `pte_req_addr` equals (`cfg_base` << 4) + (((dva AND NOT `cfg_win`) >> 10) AND NOT 3), computed 36 bits wide.
- R3: When the entry passes its checks, `rsp_fault` is 0 and `rsp_paddr` equals ((entry AND 0x07FFFF00) << 4) + dva[11:0].
- R4: An entry whose present bit (mask 0x2) is clear makes the response a fault for reads and writes alike, with `rsp_paddr` 0.
- R5: A write whose entry has the write bit (mask 0x4) clear is a fault. A read of the same entry succeeds.
- R6: A fault loads `flt_status` with 0xC0820000 for a write and with 0xC0860000 for a read. Bit 18 marks a read, and bits 31 and 17 are always set.
- R7: A fault loads `flt_addr` with the faulting dva with its low 12 bits cleared.
- R8: A successful translation leaves `flt_status` and `flt_addr` unchanged.
- R9: Each accepted request yields exactly one response. `req_ready` is 0 while a request is in flight. `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady while `rsp_ready` is 0.
- R10: Each request issues exactly one entry read. `pte_req_valid` and `pte_req_addr` hold steady until `pte_req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | AW (32) | Page-table base, shifted left by 4 to form a byte address |
| cfg_win | input | AW (32) | Window-start mask removed from the dva before indexing |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_dva | input | AW (32) | Device virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| pte_req_valid | output | 1 | Entry read request valid |
| pte_req_ready | input | 1 | Memory accepts the entry read |
| pte_req_addr | output | AW+4 (36) | Byte address of the entry |
| pte_rsp_valid | input | 1 | Entry data valid (single beat) |
| pte_rsp_data | input | PTE_W (32) | Entry data |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_paddr | output | PTE_W+4 (36) | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Translation faulted |
| flt_status | output | 32 | Captured fault status word |
| flt_addr | output | AW (32) | Captured page-aligned faulting address |

## Verification
The bench builds the block with its default parameters: 32-bit dva and entries, 4 KB pages, page-field mask 0x07FFFF00, present mask 0x2 and write mask 0x4. With these values the window sizes from 16 MB to 2 GB and base values whose shifted sum passes bit 31 are all in reach, so the carry into the upper four address bits is exercised. Random entries hit every combination of the present and write bits under both directions, and random stalls on all three handshakes exercise the hold rules.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_CHECK   = 2'd2,
    ST_RESPOND = 2'd3
  } xl_state_e;

  localparam logic [31:0] FS_ERR    = 32'h8000_0000;
  localparam logic [31:0] FS_LATE   = 32'h4000_0000;
  localparam logic [31:0] FS_FIXED  = 32'h0080_0000;
  localparam logic [31:0] FS_READ   = 32'h0004_0000;
  localparam logic [31:0] FS_AVALID = 32'h0002_0000;

  function automatic logic [31:0] fault_word(input logic is_read);
    logic [31:0] w;
    w = FS_ERR | FS_LATE | FS_FIXED | FS_AVALID;
    if (is_read) w = w | FS_READ;
    return w;
  endfunction

endpackage

// File: rtl/dvma_pte_addr.sv
module dvma_pte_addr #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] win,
  input  logic [AW-1:0] dva,
  output logic [AW+3:0] pte_addr
);
  localparam int XW    = AW + 4;
  localparam int SHIFT = PAGE_BITS - 2;

  logic [AW-1:0] rel;
  logic [XW-1:0] base_x;
  logic [XW-1:0] idx_x;

  always_comb begin
    rel      = (dva & ~win) >> SHIFT;
    base_x   = {base, 4'b0000};
    idx_x    = {4'b0000, rel} & ~XW'(3);
    pte_addr = base_x + idx_x;
  end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check #(
  parameter int                PTE_W     = 32,
  parameter int                PAGE_BITS = 12,
  parameter logic [PTE_W-1:0]  PFN_MASK  = 32'h07FF_FF00,
  parameter logic [PTE_W-1:0]  V_MASK    = 32'h0000_0002,
  parameter logic [PTE_W-1:0]  W_MASK    = 32'h0000_0004
) (
  input  logic [PTE_W-1:0]     pte,
  input  logic [PAGE_BITS-1:0] page_off,
  input  logic                 is_write,
  output logic                 fault,
  output logic [PTE_W+3:0]     paddr
);
  localparam int XW = PTE_W + 4;

  logic present;
  logic writable;
  logic [XW-1:0] frame_x;
  logic [XW-1:0] off_x;

  always_comb begin
    present  = |(pte & V_MASK);
    writable = |(pte & W_MASK);
    fault    = !present || (is_write && !writable);
    frame_x  = {pte & PFN_MASK, 4'b0000};
    off_x    = {{(XW-PAGE_BITS){1'b0}}, page_off};
    paddr    = fault ? '0 : (frame_x + off_x);
  end
endmodule

// File: rtl/dvma_fault_regs.sv
module dvma_fault_regs #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          is_read,
  input  logic [AW-1:0] dva,
  output logic [31:0]   status,
  output logic [AW-1:0] addr
);
  import dvma_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      addr   <= '0;
    end else if (upd) begin
      status <= fault_word(is_read);
      addr   <= {dva[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    end
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
  parameter int               AW        = 32,
  parameter int               PTE_W     = 32,
  parameter int               PAGE_BITS = 12,
  parameter logic [PTE_W-1:0] PFN_MASK  = 32'h07FF_FF00,
  parameter logic [PTE_W-1:0] V_MASK    = 32'h0000_0002,
  parameter logic [PTE_W-1:0] W_MASK    = 32'h0000_0004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_win,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_dva,
  input  logic             req_write,
  output logic             pte_req_valid,
  input  logic             pte_req_ready,
  output logic [AW+3:0]    pte_req_addr,
  input  logic             pte_rsp_valid,
  input  logic [PTE_W-1:0] pte_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PTE_W+3:0] rsp_paddr,
  output logic             rsp_fault,
  output logic [31:0]      flt_status,
  output logic [AW-1:0]    flt_addr
);
  import dvma_pkg::*;

  xl_state_e        state_q;
  logic [AW-1:0]    dva_q;
  logic             wr_q;
  logic             issued_q;
  logic [PTE_W-1:0] pte_q;
  logic [PTE_W+3:0] paddr_q;
  logic             fault_q;

  logic             chk_fault;
  logic [PTE_W+3:0] chk_paddr;
  logic             fault_upd;

  dvma_pte_addr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_addr (
    .base     (cfg_base),
    .win      (cfg_win),
    .dva      (dva_q),
    .pte_addr (pte_req_addr)
  );

  dvma_pte_check #(
    .PTE_W(PTE_W), .PAGE_BITS(PAGE_BITS),
    .PFN_MASK(PFN_MASK), .V_MASK(V_MASK), .W_MASK(W_MASK)
  ) u_check (
    .pte      (pte_q),
    .page_off (dva_q[PAGE_BITS-1:0]),
    .is_write (wr_q),
    .fault    (chk_fault),
    .paddr    (chk_paddr)
  );

  assign fault_upd = (state_q == ST_CHECK) && chk_fault;

  dvma_fault_regs #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_fregs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (fault_upd),
    .is_read (!wr_q),
    .dva     (dva_q),
    .status  (flt_status),
    .addr    (flt_addr)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign pte_req_valid = (state_q == ST_FETCH) && !issued_q;
  assign rsp_valid     = (state_q == ST_RESPOND);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dva_q    <= '0;
      wr_q     <= 1'b0;
      issued_q <= 1'b0;
      pte_q    <= '0;
      paddr_q  <= '0;
      fault_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            dva_q    <= req_dva;
            wr_q     <= req_write;
            issued_q <= 1'b0;
            state_q  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (!issued_q) begin
            if (pte_req_ready) issued_q <= 1'b1;
          end else if (pte_rsp_valid) begin
            pte_q   <= pte_rsp_data;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          paddr_q <= chk_paddr;
          fault_q <= chk_fault;
          state_q <= ST_RESPOND;
        end
        ST_RESPOND: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk #(
  parameter int AW    = 32,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             pte_req_valid,
  input logic             pte_req_ready,
  input logic [AW+3:0]    pte_req_addr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PTE_W+3:0] rsp_paddr,
  input logic             rsp_fault,
  input logic [31:0]      flt_status,
  input logic [AW-1:0]    flt_addr
);
  // R10
  pte_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req_valid && !pte_req_ready |=> pte_req_valid && $stable(pte_req_addr));

  // R10
  pte_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pte_req_valid && pte_req_ready |=> !pte_req_valid);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || pte_req_valid) |-> !req_ready);

  // R6
  fault_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> flt_status[31] && flt_status[17] && flt_status[23]);

  // R8
  ok_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !rsp_fault |-> $stable(flt_status) && $stable(flt_addr));
endmodule

bind dvma_xlate dvma_xlate_chk #(.AW(AW), .PTE_W(PTE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .pte_req_valid (pte_req_valid),
  .pte_req_ready (pte_req_ready),
  .pte_req_addr  (pte_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .flt_status    (flt_status),
  .flt_addr      (flt_addr)
);

// File: tb/dvma_xlate_tb.sv
`timescale 1ns/1ps
module dvma_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [31:0] cfg_win = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_dva = '0;
  logic        req_write = 1'b0;
  logic        pte_req_valid;
  logic        pte_req_ready = 1'b0;
  logic [35:0] pte_req_addr;
  logic        pte_rsp_valid = 1'b0;
  logic [31:0] pte_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [35:0] rsp_paddr;
  logic        rsp_fault;
  logic [31:0] flt_status;
  logic [31:0] flt_addr;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_fs = '0;
  logic [31:0] exp_fa = '0;

  always #2 clk = ~clk;

  dvma_xlate u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] f_pte_addr(input logic [31:0] b, input logic [31:0] w, input logic [31:0] a);
    return ({4'h0, b} << 4) + (({4'h0, a & ~w} >> 10) & ~36'h3);
  endfunction

  function automatic logic [35:0] f_paddr(input logic [31:0] p, input logic [31:0] a);
    return ({4'h0, p & 32'h07FF_FF00} << 4) + {24'h0, a[11:0]};
  endfunction

  task automatic do_req(input logic [31:0] a, input bit wr, input logic [31:0] pte);
    bit v, w, ef, hs;
    logic [35:0] epa;
    string tag;
    int n;
    v   = pte[1];
    w   = pte[2];
    ef  = !v || (wr && !w);
    epa = ef ? 36'h0 : f_paddr(pte, a);
    tag = !v ? "R4" : ((wr && !w) ? "R5" : "R3");
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 idle ready", {35'h0, req_ready}, 36'h1);
    req_valid = 1'b1; req_dva = a; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!pte_req_valid && n < 50) begin @(negedge clk); n++; end
    chk(pte_req_valid == 1'b1, "R10 read issued", {35'h0, pte_req_valid}, 36'h1);
    chk(pte_req_addr == f_pte_addr(cfg_base, cfg_win, a), "R2 entry address", pte_req_addr, f_pte_addr(cfg_base, cfg_win, a));
    hs = 1'b0;
    while (!hs) begin
      bit r;
      r = 1'($urandom % 2);
      pte_req_ready = r;
      @(negedge clk);
      pte_req_ready = 1'b0;
      hs = r;
    end
    repeat ($urandom % 3) @(negedge clk);
    chk(pte_req_valid == 1'b0, "R10 single read", {35'h0, pte_req_valid}, 36'h0);
    pte_rsp_valid = 1'b1; pte_rsp_data = pte;
    @(negedge clk);
    pte_rsp_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    chk(rsp_valid == 1'b1, "R9 response present", {35'h0, rsp_valid}, 36'h1);
    for (int k = 0; k < int'($urandom % 3); k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R9 held under back-pressure", {35'h0, rsp_valid}, 36'h1);
    end
    if (ef) begin
      exp_fs = wr ? 32'hC082_0000 : 32'hC086_0000;
      exp_fa = {a[31:12], 12'h000};
    end
    chk(rsp_fault == ef, {tag, " fault flag"}, {35'h0, rsp_fault}, {35'h0, ef});
    chk(rsp_paddr == epa, {tag, " physical address"}, rsp_paddr, epa);
    chk(flt_status == exp_fs, ef ? "R6 status word" : "R8 status kept", {4'h0, flt_status}, {4'h0, exp_fs});
    chk(flt_addr == exp_fa, ef ? "R7 fault address" : "R8 address kept", {4'h0, flt_addr}, {4'h0, exp_fa});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R9 one response", {34'h0, rsp_valid, req_ready}, 36'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", {35'h0, req_ready}, 36'h1);
    chk(!rsp_valid && !pte_req_valid, "R1 valids low", {34'h0, rsp_valid, pte_req_valid}, 36'h0);
    chk(flt_status == 32'h0 && flt_addr == 32'h0, "R1 fault regs", {4'h0, flt_status}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    cfg_base = 32'h0012_3450; cfg_win = 32'hFF00_0000;
    do_req(32'hFF12_3FFF, 1'b0, 32'h0123_4506);   // R3 read, full page offset
    do_req(32'hFF00_1000, 1'b1, 32'h0000_0000);   // R4 write, not present
    do_req(32'hFFAB_C123, 1'b0, 32'h0765_4304);   // R4 read, not present
    do_req(32'hFF45_6789, 1'b0, 32'h0111_1102);   // R5 read without write bit succeeds
    do_req(32'hFF45_6789, 1'b1, 32'h0111_1102);   // R5 write without write bit faults
    do_req(32'hFF77_7001, 1'b1, 32'h07FF_FFFE);   // R3/R8 write ok, regs kept
    cfg_base = 32'hF000_0000; cfg_win = 32'h8000_0000;
    do_req(32'hFFFF_F000, 1'b0, 32'hFFFF_FFFF);   // R2 carry into upper bits
    do_req(32'h8000_0ABC, 1'b1, 32'h0000_0006);   // R3 page zero

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [31:0] a;
      cfg_base = $urandom;
      cfg_win  = 32'hFFFF_FFFF << (24 + ($urandom % 8));
      a        = cfg_win | ($urandom & ~cfg_win);
      do_req(a, 1'($urandom % 2), $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule